// File: doc/BRIEF.md
# Column-Queue Dadda-Style Multiplier

This block is an unsigned N×N combinational multiplier with no clock. It forms every partial-product bit with an AND gate and sorts the bits into columns by weight. A row of per-column compressors, processed from least to most significant weight, brings every column down to exactly two bits. A carry-propagate adder then adds the two rows to give the upper product bits. The weight-0 bit is the lowest product bit and goes straight to the output.

Each column compressor compares its own bit count with the number of carries arriving from the column below:
- When the bits exceed the carries by more than two, half adders trim the column until the surplus is two.
- When the surplus is below two, constant-zero fillers raise it to two.
- Each incoming carry then drives one full adder. The full adder takes the two oldest bits in the column's queue, and its sum is placed at the back of that queue. Sums are therefore consumed late, which keeps the tree shallow.

Every half-adder and full-adder carry moves to the next column. The cell counts of each column are fixed when the design is built, so all wiring is static. The block sits between operand registers and product registers of the surrounding datapath.

Top module: `colq_mult`

## Requirements
- R1: `p_o` equals the unsigned product of `a_i` and `b_i` for every operand pair. It is 2N bits wide and follows the inputs combinationally, with no clock.
- R2: Product bit 0 is `a_i[0] & b_i[0]`, taken from the weight-0 partial product without passing through any adder.
- R3: When either operand is zero, the product is zero.
- R4: When one operand equals 1, the product is the other operand zero-extended to 2N bits.
- R5: Every column compressor preserves value. The ones among its partial-product bits and incoming carries equal the ones among its two remaining bits plus twice the ones among its outgoing carries.
- R6: The column of weight 2N−1 never sends a carry of value 1 toward weight 2N.
- R7: The final adder covers weights 1 to 2N−1 and never produces a carry out of its top bit.
- R8: With both operands at their maximum value, the product is exact: 255×255 gives 0xFE01 at N=8.
- R9: Exchanging the two operands leaves the product unchanged.
- R10: The width N is a parameter. At N=16 the product is exact, for example 0xFFFF×0xFFFF gives 0xFFFE0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| p_o | output | 2N | Unsigned product |

## Verification
The hardest conditions to reach from the ports are those where every full adder in the widest columns carries at once, while long runs of queued sums wait in the back half of their columns. The zero-filled top column must also stay free of real carries under those conditions. Neither condition is visible at the outputs. The stimulus reaches both with a sweep of all 65,536 operand pairs at N=8, which drives every column queue through all of its patterns, and with dense all-ones operands at both widths. The column balance and top-carry properties watch these internal conditions while the sweep runs.

// File: rtl/colq_pkg.sv
`timescale 1ns/1ps
package colq_pkg;

    typedef enum logic {CELL_HALF, CELL_FULL} cell_kind_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } sc_t;

    // number of partial-product bits of weight w for n-bit operands
    function automatic int pp_count(input int n, input int w);
        int lo;
        int hi;
        if (w < 0 || w > 2*n-2) return 0;
        hi = (w < n-1) ? w : n-1;
        lo = (w > n-1) ? w-(n-1) : 0;
        return hi - lo + 1;
    endfunction

    // lowest b-operand row contributing to weight w
    function automatic int low_row(input int n, input int w);
        return (w > n-1) ? w-(n-1) : 0;
    endfunction

    // half adders needed to bring the surplus down to two
    function automatic int half_of(input int bits, input int cin);
        return (bits - cin > 2) ? bits - cin - 2 : 0;
    endfunction

    // zero fillers needed to raise the surplus up to two
    function automatic int pad_of(input int bits, input int cin);
        return (bits - cin < 2) ? 2 - (bits - cin) : 0;
    endfunction

    // carries entering column w (columns are compressed from weight 1)
    function automatic int carry_in(input int n, input int w);
        int c;
        c = 0;
        for (int k = 1; k < w; k++)
            c = c + half_of(pp_count(n, k), c);
        return c;
    endfunction

endpackage

// File: rtl/colq_cell.sv
`timescale 1ns/1ps
module colq_cell
    import colq_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_FULL
) (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output sc_t  res_o
);

    if (KIND == CELL_HALF) begin : g_half
        logic z_unused;
        assign z_unused = z_i;
        assign res_o.sum   = x_i ^ y_i;
        assign res_o.carry = x_i & y_i;
    end else begin : g_full
        assign res_o.sum   = x_i ^ y_i ^ z_i;
        assign res_o.carry = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    end

endmodule

// File: rtl/colq_ppgen.sv
`timescale 1ns/1ps
module colq_ppgen #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [N*N-1:0] pp_o
);

    // entry r*N+c holds a[c] & b[r], weight r+c
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            assign pp_o[r*N+c] = a_i[c] & b_i[r];
        end
    end

endmodule

// File: rtl/colq_column.sv
`timescale 1ns/1ps
module colq_column
    import colq_pkg::*;
#(
    parameter int NPP   = 2,
    parameter int NCIN  = 0,
    parameter int NHALF = 0,
    parameter int NPAD  = 0,
    localparam int PW   = (NPP > 0) ? NPP : 1,
    localparam int CW   = (NCIN > 0) ? NCIN : 1,
    localparam int NCELL = NHALF + NCIN,
    localparam int OW   = (NCELL > 0) ? NCELL : 1
) (
    input  logic [PW-1:0] pp_i,
    input  logic [CW-1:0] cin_i,
    output logic [1:0]    pair_o,
    output logic [OW-1:0] cout_o
);

    localparam int BEFF = NPP + NPAD;   // queue items present before any cell

    logic [BEFF-1:0] seed;

    for (genvar i = 0; i < BEFF; i++) begin : g_seed
        if (i < NPP) begin : g_bit
            assign seed[i] = pp_i[i];
        end else begin : g_zero
            assign seed[i] = 1'b0;
        end
    end

    // cell k takes queue items 2k and 2k+1; its sum becomes item BEFF+k
    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        logic x0;
        logic x1;
        logic x2;
        sc_t  r;

        if (2*k < BEFF) begin : g_op0
            assign x0 = seed[2*k];
        end else begin : g_op0
            assign x0 = g_cell[2*k-BEFF].r.sum;
        end

        if (2*k+1 < BEFF) begin : g_op1
            assign x1 = seed[2*k+1];
        end else begin : g_op1
            assign x1 = g_cell[2*k+1-BEFF].r.sum;
        end

        if (k < NHALF) begin : g_op2
            assign x2 = 1'b0;
        end else begin : g_op2
            assign x2 = cin_i[k-NHALF];
        end

        colq_cell #(
            .KIND((k < NHALF) ? CELL_HALF : CELL_FULL)
        ) u_cell (
            .x_i   (x0),
            .y_i   (x1),
            .z_i   (x2),
            .res_o (r)
        );

        assign cout_o[k] = r.carry;
    end

    if (NCELL == 0) begin : g_no_cout
        assign cout_o = '0;
    end

    // the two items left at the head of the queue
    for (genvar q = 0; q < 2; q++) begin : g_pair
        if (2*NCELL+q < BEFF) begin : g_src
            assign pair_o[q] = seed[2*NCELL+q];
        end else begin : g_src
            assign pair_o[q] = g_cell[2*NCELL+q-BEFF].r.sum;
        end
    end

    always_comb begin
        // R5: value entering the column equals value leaving it
        a_r5_column_balance: assert ($countones(pp_i) + $countones(cin_i)
                == $countones(pair_o) + 2*$countones(cout_o))
            else $error("column balance broken");
    end

endmodule

// File: rtl/colq_cpa.sv
`timescale 1ns/1ps
module colq_cpa
    import colq_pkg::*;
#(
    parameter int W = 15
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    for (genvar k = 0; k < W; k++) begin : g_bit
        logic ci;
        sc_t  r;

        if (k == 0) begin : g_ci
            assign ci = 1'b0;
        end else begin : g_ci
            assign ci = g_bit[k-1].r.carry;
        end

        colq_cell #(.KIND(CELL_FULL)) u_fa (
            .x_i   (x_i[k]),
            .y_i   (y_i[k]),
            .z_i   (ci),
            .res_o (r)
        );

        assign sum_o[k] = r.sum;
    end

    assign cout_o = g_bit[W-1].r.carry;

endmodule

// File: rtl/colq_mult.sv
`timescale 1ns/1ps
module colq_mult
    import colq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] p_o
);

    localparam int NPROD = N * N;
    localparam int TOPW  = 2*N - 1;   // highest weight of the product
    localparam int RW    = 2*N - 1;   // final adder covers weights 1..TOPW

    logic [NPROD-1:0] pp;
    logic [RW-1:0]    row_x;
    logic [RW-1:0]    row_y;
    logic [RW-1:0]    add_sum;
    logic             add_cout;

    colq_ppgen #(.N(N)) u_ppgen (
        .a_i  (a_i),
        .b_i  (b_i),
        .pp_o (pp)
    );

    for (genvar w = 1; w <= TOPW; w++) begin : g_col
        localparam int NPP  = pp_count(N, w);
        localparam int NCIN = carry_in(N, w);
        localparam int NH   = half_of(NPP, NCIN);
        localparam int NPD  = pad_of(NPP, NCIN);
        localparam int LO   = low_row(N, w);
        localparam int PW   = (NPP > 0) ? NPP : 1;
        localparam int CW   = (NCIN > 0) ? NCIN : 1;
        localparam int OW   = (NH + NCIN > 0) ? NH + NCIN : 1;

        logic [PW-1:0] bits;
        logic [CW-1:0] cin;
        logic [OW-1:0] cout;
        logic [1:0]    pair;

        if (NPP > 0) begin : g_bits
            for (genvar t = 0; t < NPP; t++) begin : g_t
                assign bits[t] = pp[(LO+t)*N + (w-LO-t)];
            end
        end else begin : g_bits
            assign bits = 1'b0;
        end

        if (NCIN > 0) begin : g_cin
            assign cin = g_col[w-1].cout;
        end else begin : g_cin
            assign cin = '0;
        end

        colq_column #(
            .NPP   (NPP),
            .NCIN  (NCIN),
            .NHALF (NH),
            .NPAD  (NPD)
        ) u_col (
            .pp_i   (bits),
            .cin_i  (cin),
            .pair_o (pair),
            .cout_o (cout)
        );

        assign row_x[w-1] = pair[0];
        assign row_y[w-1] = pair[1];
    end

    colq_cpa #(.W(RW)) u_cpa (
        .x_i    (row_x),
        .y_i    (row_y),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    assign p_o = {add_sum, pp[0]};

    always_comb begin
        // R6: nothing of weight 2N may leave the top column
        a_r6_top_column_clear: assert (g_col[TOPW].cout == '0)
            else $error("carry left the top column");
        // R7: final adder stays inside the product width
        a_r7_adder_no_carry: assert (add_cout == 1'b0)
            else $error("final adder overflowed");
        if (a_i == '0 || b_i == '0) begin
            a_r3_zero_operand: assert (p_o == '0)
                else $error("zero operand gave nonzero product");
        end
        if (b_i == {{(N-1){1'b0}}, 1'b1}) begin
            a_r4_unit_operand: assert (p_o == {{N{1'b0}}, a_i})
                else $error("unit multiplier changed the multiplicand");
        end
    end

endmodule

// File: tb/sim_colq_mult.sv
`timescale 1ns/1ps
module sim_colq_mult;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [7:0]  a8  = '0;
    logic [7:0]  b8  = '0;
    logic [15:0] p8;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic [31:0] p16;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    colq_mult #(.N(8))  u0 (.a_i(a8),  .b_i(b8),  .p_o(p8));
    colq_mult #(.N(16)) u1 (.a_i(a16), .b_i(b16), .p_o(p16));

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] p;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd0,   8'd0,   16'h0000},
        '{8'd255, 8'd255, 16'hFE01},
        '{8'd1,   8'd255, 16'h00FF},
        '{8'd255, 8'd1,   16'h00FF},
        '{8'd128, 8'd128, 16'h4000},
        '{8'hAA,  8'h55,  16'h3872},
        '{8'd15,  8'd17,  16'h00FF},
        '{8'd200, 8'd3,   16'h0258}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic drive8(input logic [7:0] x, input logic [7:0] y);
        @(posedge clk);
        a8 = x;
        b8 = y;
        @(negedge clk);
    endtask

    task automatic drive16(input logic [15:0] x, input logic [15:0] y);
        @(posedge clk);
        a16 = x;
        b16 = y;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: operands idle at zero, R3
        check("R3 idle", {16'h0, p8}, 32'h0);
        check("R3 idle16", p16, 32'h0);

        // table of directed vectors, R1
        for (int k = 0; k < 8; k++) begin
            drive8(VECS[k].a, VECS[k].b);
            check("R1 table", {16'h0, p8}, {16'h0, VECS[k].p});
        end

        // directed corners
        drive8(8'd255, 8'd255);
        check("R8 max", {16'h0, p8}, 32'h0000FE01);
        check("R6 dense top", {16'h0, p8}, 32'h0000FE01);
        drive8(8'hFE, 8'hFF);
        check("R7 dense adder", {16'h0, p8}, 32'h0000FD02);
        drive8(8'hAA, 8'h55);
        check("R5 mixed columns", {16'h0, p8}, 32'h00003872);
        drive8(8'h00, 8'hC3);
        check("R3 zero a", {16'h0, p8}, 32'h0);
        drive8(8'h5A, 8'h00);
        check("R3 zero b", {16'h0, p8}, 32'h0);
        drive8(8'h9D, 8'h01);
        check("R4 unit b", {16'h0, p8}, 32'h0000009D);
        drive8(8'h01, 8'hE7);
        check("R4 unit a", {16'h0, p8}, 32'h000000E7);

        // bit 0 for all four low-bit combinations with busy upper bits, R2
        for (int q = 0; q < 4; q++) begin
            drive8({7'h7F, q[0]}, {7'h55, q[1]});
            check("R2 bit0", {31'h0, p8[0]}, {31'h0, q[0] & q[1]});
        end

        // exhaustive sweep at N=8, R1
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                drive8(x[7:0], y[7:0]);
                check("R1 sweep", {16'h0, p8}, 32'(x * y));
            end
        end

        // wide instance, R10
        drive16(16'hFFFF, 16'hFFFF);
        check("R10 max16", p16, 32'hFFFE0001);
        drive16(16'h8000, 16'h0002);
        check("R10 shift16", p16, 32'h00010000);
        for (int n = 0; n < 1000; n++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom);
            y = 16'($urandom);
            drive16(x, y);
            check("R10 random16", p16, 32'(x) * 32'(y));
        end

        // operand exchange, R9
        for (int n = 0; n < 200; n++) begin
            logic [15:0] x;
            logic [15:0] y;
            logic [31:0] first;
            x = 16'($urandom);
            y = 16'($urandom);
            drive16(x, y);
            first = p16;
            drive16(y, x);
            check("R9 swap", p16, first);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule